// File: doc/BRIEF.md
# Prioritized Address Window Decoder

This block takes a 36-bit transaction address and a snoop attribute, and picks the destination interface. It compares the address against a set of programmable windows. Each window has a power-of-two size and covers a naturally aligned range. Only the address bits above the window size take part in the compare.

The window kinds are checked in a fixed order:

1. A fixed-size window for the configuration registers. It is always on and always wins.
2. Two on-chip SRAM windows. They claim only snooped traffic and replace the upper address bits with a translation base.
3. Twelve general routing windows. Each carries its own target code and does no translation.
4. A fixed boot region at the top of the address space, used only when nothing above it matches.

Anything that is still unmatched is a decode miss. All windows are programmed through a single-cycle write port. The decode is combinational, and the result is captured in one output register stage.

Top module: `addr_window_decoder`

## Requirements
- R1: While `rst_ni` is low, `hit_o`, `err_o`, `boot_o`, `tgt_o` and `addr_o` are all zero. After reset every SRAM window and routing window is disabled, and the configuration window sits at base 0x0_FF70_0000.
- R2: Configuration window match. An address whose bits [35:20] equal the configuration base gives `tgt_o` = 30 (0x1E) and `hit_o` = 1. The address passes through unchanged. This window overrides every other window and the boot region.
- R3: SRAM window match. Three conditions must hold: `snoop_i` is 1, the window is enabled, and its size code is 15 to 17 (64 KB to 256 KB). When the address bits above the window size equal the window base, `tgt_o` = 29 (0x1D). `addr_o` then takes the translation base in the bits above the window size and keeps the incoming address bits below it.
- R4: When `snoop_i` is 0, no SRAM window matches. Such an address is decoded by the routing windows, the boot region or the miss rule instead.
- R5: Routing window match. An enabled routing window with size code 11 to 35 matches when the address bits above its size equal its base. The result is `tgt_o` = the window's programmed target, `hit_o` = 1 and an unchanged address.
- R6: When several routing windows match, the lowest-numbered one supplies the target.
- R7: The size field encodes log2(bytes) - 1. A window whose size code is outside its allowed range never matches: below 11 for routing windows, outside 15 to 17 for SRAM windows.
- R8: Boot region. An address with bits [35:23] all ones that matches no other window gives `tgt_o` = 28 (0x1C), `boot_o` = 1 and `hit_o` = 1.
- R9: Decode miss. An address that matches nothing gives `err_o` = 1, `hit_o` = 0, `tgt_o` = 31 (all ones) and an unchanged address.
- R10: All outputs are registered. Every address and snoop value sampled at a clock edge yields exactly one of `hit_o` or `err_o` after that edge.
- R11: A write that is accepted at a clock edge affects decodes sampled at the following edge, and not the decode sampled at the same edge. The write kind field selects what is written: 0 = configuration base (from `wr_base_i[23:8]`), 1 = SRAM window, 2 = routing window, 3 = nothing. A write with kind 3, or with an index beyond the windows present, changes nothing.
- R12: For snooped traffic, an SRAM window overrides a routing window at the same address. A routing window overrides the boot region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 36 | Transaction address |
| snoop_i | input | 1 | Transaction is snooped |
| wr_i | input | 1 | Window write strobe |
| wr_kind_i | input | 2 | 0 config base, 1 SRAM, 2 routing, 3 none |
| wr_idx_i | input | 4 | Window index within its kind |
| wr_ena_i | input | 1 | Window enable value |
| wr_base_i | input | 24 | Base address bits [35:12] |
| wr_xlat_i | input | 24 | Translation base bits [35:12] (SRAM only) |
| wr_size_i | input | 6 | Size code, log2(bytes) - 1 |
| wr_tgt_i | input | 5 | Target code (routing only) |
| hit_o | output | 1 | Some window or the boot region matched |
| err_o | output | 1 | Decode miss |
| boot_o | output | 1 | Boot region selected |
| tgt_o | output | 5 | Selected target code |
| addr_o | output | 36 | Output (possibly translated) address |

## Verification
Every decode result appears one clock edge after its address and snoop value are sampled. The bench therefore drives its inputs on the falling edge, waits for the next rising edge, and samples shortly after it.

A write takes part in decoding one edge later than an address presented with it. To follow this, the bench computes each expected result from its own model of the window registers before it applies that cycle's write. A directed case presents an address alongside the write that would change its outcome, and checks that the old outcome still appears.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W    = 36;
  localparam int PAGE_LSB  = 12;
  localparam int BASE_W    = ADDR_W - PAGE_LSB;
  localparam int CFG_LSB   = 20;
  localparam int CFG_W     = ADDR_W - CFG_LSB;
  localparam int BOOT_LSB  = 23;
  localparam int SIZE_W    = 6;
  localparam int TGT_W     = 5;
  localparam int IDX_W     = 4;

  localparam logic [SIZE_W-1:0] CFG_CODE     = SIZE_W'(CFG_LSB - 1);
  localparam logic [SIZE_W-1:0] LAW_MIN_CODE = SIZE_W'(PAGE_LSB - 1);
  localparam logic [SIZE_W-1:0] LAW_MAX_CODE = SIZE_W'(ADDR_W - 1);
  localparam logic [SIZE_W-1:0] SRAM_MIN_CODE = 6'd15;
  localparam logic [SIZE_W-1:0] SRAM_MAX_CODE = 6'd17;

  localparam logic [TGT_W-1:0] TGT_MISS = '1;
  localparam logic [TGT_W-1:0] TGT_CFG  = TGT_MISS - 1;
  localparam logic [TGT_W-1:0] TGT_SRAM = TGT_MISS - 2;
  localparam logic [TGT_W-1:0] TGT_BOOT = TGT_MISS - 3;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_SRAM = 2'd1,
    KIND_LAW  = 2'd2,
    KIND_NONE = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] xlat;
    logic [SIZE_W-1:0] size;
  } sram_win_t;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] size;
    logic [TGT_W-1:0]  tgt;
  } law_win_t;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int               N_SRAM  = 2,
  parameter int               N_LAW   = 12,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h0FF7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [1:0]             wr_kind_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic                   wr_ena_i,
  input  logic [BASE_W-1:0]      wr_base_i,
  input  logic [BASE_W-1:0]      wr_xlat_i,
  input  logic [SIZE_W-1:0]      wr_size_i,
  input  logic [TGT_W-1:0]       wr_tgt_i,
  output logic [CFG_W-1:0]       cfg_base_o,
  output sram_win_t [N_SRAM-1:0] sram_o,
  output law_win_t  [N_LAW-1:0]  law_o
);
  logic [CFG_W-1:0]       cfg_q;
  sram_win_t [N_SRAM-1:0] sram_q;
  law_win_t  [N_LAW-1:0]  law_q;
  wr_kind_e               kind;

  assign kind = wr_kind_e'(wr_kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      sram_q <= '0;
      law_q  <= '0;
    end else if (wr_i) begin
      if (kind == KIND_CFG) cfg_q <= wr_base_i[BASE_W-1 -: CFG_W];
      for (int i = 0; i < N_SRAM; i++) begin
        if (kind == KIND_SRAM && wr_idx_i == IDX_W'(i)) begin
          sram_q[i].en   <= wr_ena_i;
          sram_q[i].base <= wr_base_i;
          sram_q[i].xlat <= wr_xlat_i;
          sram_q[i].size <= wr_size_i;
        end
      end
      for (int i = 0; i < N_LAW; i++) begin
        if (kind == KIND_LAW && wr_idx_i == IDX_W'(i)) begin
          law_q[i].en   <= wr_ena_i;
          law_q[i].base <= wr_base_i;
          law_q[i].size <= wr_size_i;
          law_q[i].tgt  <= wr_tgt_i;
        end
      end
    end
  end

  assign cfg_base_o = cfg_q;
  assign sram_o     = sram_q;
  assign law_o      = law_q;

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || kind == KIND_NONE) |=> ($stable(cfg_q) && $stable(sram_q) && $stable(law_q))); // R11
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter logic [SIZE_W-1:0] MIN_CODE = LAW_MIN_CODE,
  parameter logic [SIZE_W-1:0] MAX_CODE = LAW_MAX_CODE
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};
  logic [ADDR_W:0]   span;
  logic              legal;
  logic [ADDR_W-1:0] diff;

  // span covers the offset bits: 2^(code+1) - 1
  assign span   = (ONE << ({1'b0, size_i} + 7'd1)) - ONE;
  assign mask_o = ~span[ADDR_W-1:0];
  assign legal  = (size_i >= MIN_CODE) && (size_i <= MAX_CODE);
  assign diff   = (addr_i ^ {base_i, {PAGE_LSB{1'b0}}}) & mask_o;
  assign hit_o  = en_i && legal && (diff == '0);
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int               N_SRAM  = 2,
  parameter int               N_LAW   = 12,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h0FF7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               snoop_i,
  input  logic               wr_i,
  input  logic [1:0]         wr_kind_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_ena_i,
  input  logic [BASE_W-1:0]  wr_base_i,
  input  logic [BASE_W-1:0]  wr_xlat_i,
  input  logic [SIZE_W-1:0]  wr_size_i,
  input  logic [TGT_W-1:0]   wr_tgt_i,
  output logic               hit_o,
  output logic               err_o,
  output logic               boot_o,
  output logic [TGT_W-1:0]   tgt_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int SRAM_IW = (N_SRAM > 1) ? $clog2(N_SRAM) : 1;
  localparam int LAW_IW  = (N_LAW > 1) ? $clog2(N_LAW) : 1;

  logic [CFG_W-1:0]       cfg_base;
  sram_win_t [N_SRAM-1:0] sram_q;
  law_win_t  [N_LAW-1:0]  law_q;

  awd_regs #(.N_SRAM(N_SRAM), .N_LAW(N_LAW), .CFG_RST(CFG_RST)) u_regs (
    .clk_i, .rst_ni, .wr_i, .wr_kind_i, .wr_idx_i, .wr_ena_i,
    .wr_base_i, .wr_xlat_i, .wr_size_i, .wr_tgt_i,
    .cfg_base_o(cfg_base), .sram_o(sram_q), .law_o(law_q)
  );

  // configuration window: fixed 1 MB, always on
  logic              cfg_hit;
  logic [ADDR_W-1:0] cfg_mask;
  awd_win_match #(.MIN_CODE(CFG_CODE), .MAX_CODE(CFG_CODE)) u_cfg_match (
    .addr_i, .en_i(1'b1),
    .base_i({cfg_base, {(CFG_LSB - PAGE_LSB){1'b0}}}),
    .size_i(CFG_CODE), .hit_o(cfg_hit), .mask_o(cfg_mask)
  );

  logic [N_SRAM-1:0] sram_hit;
  logic [ADDR_W-1:0] sram_mask [N_SRAM];
  logic [N_LAW-1:0]  law_hit;
  logic [ADDR_W-1:0] law_mask  [N_LAW];

  for (genvar g = 0; g < N_SRAM; g++) begin : g_sram
    awd_win_match #(.MIN_CODE(SRAM_MIN_CODE), .MAX_CODE(SRAM_MAX_CODE)) u_match (
      .addr_i, .en_i(sram_q[g].en), .base_i(sram_q[g].base),
      .size_i(sram_q[g].size), .hit_o(sram_hit[g]), .mask_o(sram_mask[g])
    );
  end

  for (genvar g = 0; g < N_LAW; g++) begin : g_law
    awd_win_match #(.MIN_CODE(LAW_MIN_CODE), .MAX_CODE(LAW_MAX_CODE)) u_match (
      .addr_i, .en_i(law_q[g].en), .base_i(law_q[g].base),
      .size_i(law_q[g].size), .hit_o(law_hit[g]), .mask_o(law_mask[g])
    );
  end

  logic               sram_any, law_any;
  logic [SRAM_IW-1:0] sram_idx;
  logic [LAW_IW-1:0]  law_idx;

  awd_prio #(.N(N_SRAM), .IW(SRAM_IW)) u_sram_prio (
    .hit_i(sram_hit), .any_o(sram_any), .idx_o(sram_idx)
  );
  awd_prio #(.N(N_LAW), .IW(LAW_IW)) u_law_prio (
    .hit_i(law_hit), .any_o(law_any), .idx_o(law_idx)
  );

  // translate through the winning SRAM window; fetch winning routing target
  logic [ADDR_W-1:0] sram_xaddr;
  logic [TGT_W-1:0]  law_tgt;
  always_comb begin
    sram_xaddr = addr_i;
    law_tgt    = '0;
    for (int i = 0; i < N_SRAM; i++) begin
      if (sram_idx == SRAM_IW'(i))
        sram_xaddr = ({sram_q[i].xlat, {PAGE_LSB{1'b0}}} & sram_mask[i]) |
                     (addr_i & ~sram_mask[i]);
    end
    for (int i = 0; i < N_LAW; i++) begin
      if (law_idx == LAW_IW'(i)) law_tgt = law_q[i].tgt;
    end
  end

  logic              boot_hit;
  logic              d_hit, d_err, d_boot;
  logic [TGT_W-1:0]  d_tgt;
  logic [ADDR_W-1:0] d_addr;

  assign boot_hit = &addr_i[ADDR_W-1:BOOT_LSB];

  always_comb begin
    d_hit  = 1'b1;
    d_err  = 1'b0;
    d_boot = 1'b0;
    d_tgt  = TGT_MISS;
    d_addr = addr_i;
    if (cfg_hit) begin
      d_tgt = TGT_CFG;
    end else if (snoop_i && sram_any) begin
      d_tgt  = TGT_SRAM;
      d_addr = sram_xaddr;
    end else if (law_any) begin
      d_tgt = law_tgt;
    end else if (boot_hit) begin
      d_tgt  = TGT_BOOT;
      d_boot = 1'b1;
    end else begin
      d_hit = 1'b0;
      d_err = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      err_o  <= 1'b0;
      boot_o <= 1'b0;
      tgt_o  <= '0;
      addr_o <= '0;
    end else begin
      hit_o  <= d_hit;
      err_o  <= d_err;
      boot_o <= d_boot;
      tgt_o  <= d_tgt;
      addr_o <= d_addr;
    end
  end

  AST_CFG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_hit |=> (tgt_o == TGT_CFG && addr_o == $past(addr_i))); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (addr_o[PAGE_LSB-1:0] == $past(addr_i[PAGE_LSB-1:0]))); // R3
  AST_BOOT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_o |-> (hit_o && tgt_o == TGT_BOOT)); // R8
  AST_MISS_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!hit_o && tgt_o == TGT_MISS)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones({hit_o, err_o}) == 1); // R10
endmodule

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] addr = '0;
  logic        snoop = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  wr_kind = 2'd3;
  logic [3:0]  wr_idx = '0;
  logic        wr_ena = 1'b0;
  logic [23:0] wr_base = '0, wr_xlat = '0;
  logic [5:0]  wr_size = '0;
  logic [4:0]  wr_tgt = '0;
  logic        hit, err, boot;
  logic [4:0]  tgt;
  logic [35:0] oaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  addr_window_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .snoop_i(snoop),
    .wr_i(wr), .wr_kind_i(wr_kind), .wr_idx_i(wr_idx), .wr_ena_i(wr_ena),
    .wr_base_i(wr_base), .wr_xlat_i(wr_xlat), .wr_size_i(wr_size), .wr_tgt_i(wr_tgt),
    .hit_o(hit), .err_o(err), .boot_o(boot), .tgt_o(tgt), .addr_o(oaddr)
  );

  // bench model of the window registers
  logic [15:0] m_cfg;
  logic        m_s_en   [2];
  logic [23:0] m_s_base [2];
  logic [23:0] m_s_xl   [2];
  logic [5:0]  m_s_sz   [2];
  logic        m_l_en   [12];
  logic [23:0] m_l_base [12];
  logic [5:0]  m_l_sz   [12];
  logic [4:0]  m_l_tgt  [12];

  typedef struct packed {
    logic        hit, err, boot;
    logic [4:0]  tgt;
    logic [35:0] addr;
  } res_t;

  function automatic logic [35:0] hi_mask(input logic [5:0] code);
    logic [36:0] s;
    s = (37'd1 << (code + 7'd1)) - 37'd1;
    return ~s[35:0];
  endfunction

  function automatic bit in_win(input logic [35:0] a, input logic [23:0] b, input logic [5:0] c);
    return ((a ^ {b, 12'h000}) & hi_mask(c)) == 36'd0;
  endfunction

  function automatic res_t expect_of(input logic [35:0] a, input logic s);
    res_t r;
    r = '{hit: 1'b1, err: 1'b0, boot: 1'b0, tgt: 5'd31, addr: a};
    if (a[35:20] == m_cfg) begin
      r.tgt = 5'd30;
      return r;
    end
    if (s) begin
      for (int i = 0; i < 2; i++) begin
        if (m_s_en[i] && m_s_sz[i] >= 15 && m_s_sz[i] <= 17 && in_win(a, m_s_base[i], m_s_sz[i])) begin
          r.tgt  = 5'd29;
          r.addr = ({m_s_xl[i], 12'h000} & hi_mask(m_s_sz[i])) | (a & ~hi_mask(m_s_sz[i]));
          return r;
        end
      end
    end
    for (int i = 0; i < 12; i++) begin
      if (m_l_en[i] && m_l_sz[i] >= 11 && m_l_sz[i] <= 35 && in_win(a, m_l_base[i], m_l_sz[i])) begin
        r.tgt = m_l_tgt[i];
        return r;
      end
    end
    if (&a[35:23]) begin
      r.tgt  = 5'd28;
      r.boot = 1'b1;
      return r;
    end
    r.hit = 1'b0;
    r.err = 1'b1;
    return r;
  endfunction

  task automatic model_write();
    if (!wr) return;
    case (wr_kind)
      2'd0: m_cfg = wr_base[23:8];
      2'd1: if (wr_idx < 2) begin
              m_s_en[wr_idx] = wr_ena; m_s_base[wr_idx] = wr_base;
              m_s_xl[wr_idx] = wr_xlat; m_s_sz[wr_idx] = wr_size;
            end
      2'd2: if (wr_idx < 12) begin
              m_l_en[wr_idx] = wr_ena; m_l_base[wr_idx] = wr_base;
              m_l_sz[wr_idx] = wr_size; m_l_tgt[wr_idx] = wr_tgt;
            end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag, input res_t e);
    res_t a;
    a = '{hit: hit, err: err, boot: boot, tgt: tgt, addr: oaddr};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual hit=%0b err=%0b boot=%0b tgt=%0d addr=%h expected hit=%0b err=%0b boot=%0b tgt=%0d addr=%h",
               tag, a.hit, a.err, a.boot, a.tgt, a.addr, e.hit, e.err, e.boot, e.tgt, e.addr);
    end
  endtask

  // one cycle: drive at falling edge, sample after next rising edge
  task automatic step(input string tag, input logic [35:0] a, input logic s,
                      input logic w = 1'b0, input logic [1:0] k = 2'd3, input logic [3:0] ix = '0,
                      input logic en = 1'b0, input logic [35:0] base = '0, input logic [35:0] xl = '0,
                      input logic [5:0] sz = '0, input logic [4:0] tg = '0);
    res_t e;
    @(negedge clk);
    addr = a; snoop = s; wr = w; wr_kind = k; wr_idx = ix; wr_ena = en;
    wr_base = base[35:12]; wr_xlat = xl[35:12]; wr_size = sz; wr_tgt = tg;
    e = expect_of(a, s);
    @(posedge clk);
    #1;
    compare(tag, e);
    model_write();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10: watchdog expired, actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cfg = 16'h0FF7;
    for (int i = 0; i < 2; i++) begin
      m_s_en[i] = 0; m_s_base[i] = 0; m_s_xl[i] = 0; m_s_sz[i] = 0;
    end
    for (int i = 0; i < 12; i++) begin
      m_l_en[i] = 0; m_l_base[i] = 0; m_l_sz[i] = 0; m_l_tgt[i] = 0;
    end

    repeat (3) @(posedge clk);
    #1;
    compare("R1", '{hit: 0, err: 0, boot: 0, tgt: 0, addr: 0});
    @(negedge clk);
    rst_n = 1'b1;

    step("R1", 36'h0_FF71_2345, 1'b0);             // reset config base
    step("R2", 36'hF_FFFF_FFF0 & 36'h0_FF7F_FFFF, 1'b1);
    step("R9", 36'h1_0000_0000, 1'b0);
    step("R8", 36'hF_FFFF_FFF0, 1'b0);
    step("R11", 36'h1_0000_0010, 1'b0, 1'b1, 2'd2, 4'd3, 1'b1, 36'h1_0000_0000, 36'h0, 6'd27, 5'd5);
    step("R5", 36'h1_0000_0010, 1'b0);
    step("R5", 36'h1_0FFF_FFFF, 1'b1);
    step("R9", 36'h1_1000_0000, 1'b1);
    step("R6", 36'h1_0800_0040, 1'b0, 1'b1, 2'd2, 4'd1, 1'b1, 36'h1_0800_0000, 36'h0, 6'd26, 5'd7);
    step("R6", 36'h1_0800_0040, 1'b0);
    step("R6", 36'h1_0000_0040, 1'b0);
    step("R7", 36'h1_0800_0000, 1'b0, 1'b1, 2'd2, 4'd0, 1'b1, 36'h1_0800_0000, 36'h0, 6'd10, 5'd9);
    step("R7", 36'h1_0800_0000, 1'b0);
    step("R3", 36'h1_0800_1234, 1'b1, 1'b1, 2'd1, 4'd0, 1'b1, 36'h1_0800_0000, 36'h2_2222_0000, 6'd16, 5'd0);
    step("R3", 36'h1_0800_1234, 1'b1);
    step("R12", 36'h1_0801_FFFF, 1'b1);
    step("R4", 36'h1_0800_1234, 1'b0);
    step("R3", 36'h1_0802_0000, 1'b1);
    step("R7", 36'h1_0800_1234, 1'b1, 1'b1, 2'd1, 4'd1, 1'b1, 36'h1_0800_0000, 36'h3_0000_0000, 6'd20, 5'd0);
    step("R7", 36'h1_0800_1234, 1'b1, 1'b1, 2'd1, 4'd0, 1'b1, 36'h1_0800_0000, 36'h2_2222_0000, 6'd20, 5'd0);
    step("R7", 36'h1_0800_1234, 1'b1);
    step("R12", 36'hF_FF80_0000, 1'b0, 1'b1, 2'd2, 4'd11, 1'b1, 36'hF_FF00_0000, 36'h0, 6'd23, 5'd12);
    step("R12", 36'hF_FF80_0000, 1'b0);
    step("R2", 36'h1_0800_1234, 1'b1, 1'b1, 2'd0, 4'd0, 1'b0, 36'h1_0800_0000, 36'h0, 6'd0, 5'd0);
    step("R2", 36'h1_0800_1234, 1'b1);
    step("R11", 36'h3_0000_0000, 1'b0, 1'b1, 2'd2, 4'd14, 1'b1, 36'h3_0000_0000, 36'h0, 6'd20, 5'd3);
    step("R11", 36'h3_0000_0000, 1'b0, 1'b1, 2'd3, 4'd2, 1'b1, 36'h3_0000_0000, 36'h0, 6'd20, 5'd3);
    step("R11", 36'h3_0000_0000, 1'b0);

    for (int n = 0; n < 600; n++) begin
      logic [35:0] a, b;
      logic [3:0]  ix;
      logic        w;
      int          pick;
      pick = $urandom_range(0, 5);
      ix   = 4'($urandom_range(0, 11));
      case (pick)
        0: a = {4'($urandom), $urandom};
        1: a = {m_l_base[ix], 12'h000} ^ 36'($urandom_range(0, 32'h3FFFF));
        2: a = {m_s_base[ix[0]], 12'h000} ^ 36'($urandom_range(0, 32'h7FFFF));
        3: a = {m_cfg, 20'h00000} ^ 36'($urandom_range(0, 32'h1FFFFF));
        4: a = {13'h1FFF, 23'($urandom)};
        default: a = {m_l_base[ix], 12'h000} | 36'($urandom_range(0, 32'hFFF));
      endcase
      w = ($urandom_range(0, 4) == 0);
      b = {4'($urandom_range(0, 3)), $urandom} & ~36'hFFF;
      step("R10", a, 1'($urandom), w, 2'($urandom_range(0, 3) == 0 ? 3 : $urandom_range(1, 2)),
           4'($urandom_range(0, 13)), 1'($urandom_range(0, 7) != 0), b,
           {4'($urandom), $urandom}, 6'($urandom_range(8, 37)), 5'($urandom_range(0, 27)));
    end

    done = 1'b1;
    finish_run();
  end
endmodule